// File: doc/BRIEF.md
# Dadda Tree Multiplier, 4x4 Unsigned

This block multiplies two unsigned 4-bit operands and returns their 8-bit product in a single combinational pass. An AND array forms all sixteen partial-product dots at once, each dot being one multiplier bit gated with one multiplicand bit. A reduction network of explicit full-adder and half-adder cells brings the dot matrix down to two rows in carry-save form. A ripple carry-propagate adder then turns those two rows into the binary result, and its carry-out supplies the top product bit.

The reduction network is written cell by cell, so its structure is fixed in the source and can be reviewed. The default schedule delays every combination as long as the tree depth allows. A parameter selects the alternative schedule, which combines dots as early as possible, so the two can be compared side by side. Three constant outputs report the cell budget and the final-adder width of the selected schedule. The block is meant for datapaths that need a small multiply with a known, reviewable gate structure. It has no clock and no state.

Top module: `tree_mult4`

## Requirements
- R1: With the late-combining schedule (SCHED = SCHED_DADDA, the default), `product` equals `opa * opb` for all 256 operand pairs.
- R2: With the early-combining schedule (SCHED = SCHED_WALLACE), `product` equals `opa * opb` for all 256 operand pairs.
- R3: `product[7]` is the carry-out of the final adder: it is 1 exactly when `opa * opb` is 128 or more.
- R4: The late-combining schedule reports 4 full-adder cells and 2 half-adder cells on `fa_cells` and `ha_cells`.
- R5: The early-combining schedule reports 5 full-adder cells and 3 half-adder cells on `fa_cells` and `ha_cells`.
- R6: `cpa_bits` reports the width of the final carry-propagate adder: 6 for the late-combining schedule and 4 for the early-combining one.
- R7: When either operand is zero, `product` is zero.
- R8: `product` never exceeds 225, the product of the two largest operands.
- R9: `product[0]` equals `opa[0] & opb[0]`, because the least significant column holds a single dot that bypasses the tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | Unsigned multiplicand |
| opb | input | 4 | Unsigned multiplier |
| product | output | 8 | Unsigned product; bit 7 is the final adder's carry-out |
| fa_cells | output | 4 | Number of full-adder cells in the selected reduction network |
| ha_cells | output | 4 | Number of half-adder cells in the selected reduction network |
| cpa_bits | output | 4 | Width of the final carry-propagate adder for the selected schedule |

## Verification
The full sweep of all 256 operand pairs runs on two instances, one for each schedule. Any misplaced dot, any dropped carry or any wrong column weight therefore shows up as a wrong product for some pair. A short table of corner operands comes first. All-ones operands drive the longest carry chain into bit 7. A zero on either side shows whether the AND array gates every dot. Single-bit and asymmetric operands light up individual columns and tell a transposed row from a transposed column. Directed checks then compare the reported cell counts and adder widths of the two schedules. They also check bit 7 around the 128 threshold and the bypassed least significant bit.

// File: rtl/tree_mult_pkg.sv
`timescale 1ns/1ps
package tree_mult_pkg;

    // Reduction schedule selector.
    typedef enum logic {
        SCHED_DADDA   = 1'b0,
        SCHED_WALLACE = 1'b1
    } sched_e;

    // The netlist below is hand-placed for this operand width.
    localparam int OPW     = 4;
    localparam int PRODW   = 2 * OPW;
    localparam int MAXPROD = ((1 << OPW) - 1) * ((1 << OPW) - 1);

    // Cell budgets of each hand-placed schedule.
    localparam int DADDA_FA    = 4;
    localparam int DADDA_HA    = 2;
    localparam int DADDA_CPA   = 6;
    localparam int WALLACE_FA  = 5;
    localparam int WALLACE_HA  = 3;
    localparam int WALLACE_CPA = 4;
    localparam int CNTW        = 4;

endpackage

// File: rtl/tm_full_add.sv
`timescale 1ns/1ps
module tm_full_add (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);
    logic xy;

    assign xy = x ^ y;
    assign s  = xy ^ z;
    assign co = (x & y) | (z & xy);

    always_comb begin
        assert_fa_sum_R1: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {1'b0, z}))
            else $error("full adder weight mismatch");
    end
endmodule

// File: rtl/tm_half_add.sv
`timescale 1ns/1ps
module tm_half_add (
    input  logic x,
    input  logic y,
    output logic s,
    output logic co
);
    assign s  = x ^ y;
    assign co = x & y;

    always_comb begin
        assert_ha_sum_R2: assert ({co, s} == ({1'b0, x} + {1'b0, y}))
            else $error("half adder weight mismatch");
    end
endmodule

// File: rtl/tm_ripple_cpa.sv
`timescale 1ns/1ps
module tm_ripple_cpa #(
    parameter int W = 6
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        tm_full_add u_fa (
            .x (x[k]),
            .y (y[k]),
            .z (c[k]),
            .s (sum[k]),
            .co(c[k+1])
        );
    end

    assign co = c[W];

    always_comb begin
        assert_cpa_sum_R3: assert ({co, sum} == ({1'b0, x} + {1'b0, y}))
            else $error("carry-propagate adder mismatch");
    end
endmodule

// File: rtl/tm_pp_gen.sv
`timescale 1ns/1ps
module tm_pp_gen #(
    parameter int N = 4
) (
    input  logic [N-1:0]         mcand,
    input  logic [N-1:0]         mplier,
    output logic [N-1:0][N-1:0]  pp     // pp[i][j] has weight i+j
);
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign pp[i][j] = mplier[i] & mcand[j];
        end
    end
endmodule

// File: rtl/tree_mult4.sv
`timescale 1ns/1ps
module tree_mult4
    import tree_mult_pkg::*;
#(
    parameter sched_e SCHED = SCHED_DADDA
) (
    input  logic [OPW-1:0]   opa,
    input  logic [OPW-1:0]   opb,
    output logic [PRODW-1:0] product,
    output logic [CNTW-1:0]  fa_cells,
    output logic [CNTW-1:0]  ha_cells,
    output logic [CNTW-1:0]  cpa_bits
);
    logic [OPW-1:0][OPW-1:0] pp;

    tm_pp_gen #(.N(OPW)) u_pp (
        .mcand (opa),
        .mplier(opb),
        .pp    (pp)
    );

    if (SCHED == SCHED_DADDA) begin : g_dadda
        // Stage 1: bring the height-4 column down to 3, late as possible.
        logic h0_s, h0_c, h1_s, h1_c;
        tm_half_add u_h0 (.x(pp[0][3]), .y(pp[1][2]), .s(h0_s), .co(h0_c));
        tm_half_add u_h1 (.x(pp[1][3]), .y(pp[2][2]), .s(h1_s), .co(h1_c));

        // Stage 2: every column down to 2.
        logic f0_s, f0_c, f1_s, f1_c, f2_s, f2_c, f3_s, f3_c;
        tm_full_add u_f0 (.x(pp[0][2]), .y(pp[1][1]), .z(pp[2][0]), .s(f0_s), .co(f0_c));
        tm_full_add u_f1 (.x(h0_s),     .y(pp[2][1]), .z(pp[3][0]), .s(f1_s), .co(f1_c));
        tm_full_add u_f2 (.x(h1_s),     .y(pp[3][1]), .z(h0_c),     .s(f2_s), .co(f2_c));
        tm_full_add u_f3 (.x(pp[2][3]), .y(pp[3][2]), .z(h1_c),     .s(f3_s), .co(f3_c));

        // Final adder spans columns 1..6.
        logic [DADDA_CPA-1:0] sum;
        logic                 co;
        tm_ripple_cpa #(.W(DADDA_CPA)) u_cpa (
            .x  ({pp[3][3], f3_s, f2_s, f1_s, f0_s, pp[0][1]}),
            .y  ({f3_c,     f2_c, f1_c, f0_c, 1'b0, pp[1][0]}),
            .sum(sum),
            .co (co)
        );

        assign product  = {co, sum, pp[0][0]};
        assign fa_cells = CNTW'(DADDA_FA);
        assign ha_cells = CNTW'(DADDA_HA);
        assign cpa_bits = CNTW'(DADDA_CPA);
    end else begin : g_wallace
        // Stage 1: rows 0..2 as a carry-save group, early as possible.
        logic h0_s, h0_c, h1_s, h1_c, f0_s, f0_c, f1_s, f1_c;
        tm_half_add u_h0 (.x(pp[0][1]), .y(pp[1][0]), .s(h0_s), .co(h0_c));
        tm_full_add u_f0 (.x(pp[0][2]), .y(pp[1][1]), .z(pp[2][0]), .s(f0_s), .co(f0_c));
        tm_full_add u_f1 (.x(pp[0][3]), .y(pp[1][2]), .z(pp[2][1]), .s(f1_s), .co(f1_c));
        tm_half_add u_h1 (.x(pp[1][3]), .y(pp[2][2]), .s(h1_s), .co(h1_c));

        // Stage 2: everything with two or more dots is combined.
        logic h2_s, h2_c, f2_s, f2_c, f3_s, f3_c, f4_s, f4_c;
        tm_half_add u_h2 (.x(f0_s),     .y(h0_c),                   .s(h2_s), .co(h2_c));
        tm_full_add u_f2 (.x(f1_s),     .y(f0_c), .z(pp[3][0]),     .s(f2_s), .co(f2_c));
        tm_full_add u_f3 (.x(h1_s),     .y(f1_c), .z(pp[3][1]),     .s(f3_s), .co(f3_c));
        tm_full_add u_f4 (.x(pp[2][3]), .y(h1_c), .z(pp[3][2]),     .s(f4_s), .co(f4_c));

        // Final adder spans columns 3..6.
        logic [WALLACE_CPA-1:0] sum;
        logic                   co;
        tm_ripple_cpa #(.W(WALLACE_CPA)) u_cpa (
            .x  ({pp[3][3], f4_s, f3_s, f2_s}),
            .y  ({f4_c,     f3_c, f2_c, h2_c}),
            .sum(sum),
            .co (co)
        );

        assign product  = {co, sum, h2_s, h0_s, pp[0][0]};
        assign fa_cells = CNTW'(WALLACE_FA);
        assign ha_cells = CNTW'(WALLACE_HA);
        assign cpa_bits = CNTW'(WALLACE_CPA);
    end

    always_comb begin
        assert_range_R8: assert (product <= PRODW'(MAXPROD))
            else $error("product above largest reachable value");
        assert_zero_R7: assert (!((opa == '0) || (opb == '0)) || (product == '0))
            else $error("zero operand gave nonzero product");
    end
endmodule

// File: tb/tb_tree_mult4.sv
`timescale 1ns/1ps
module tb_tree_mult4;
    import tree_mult_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0] a, b;
    logic [7:0] p_d, p_w;
    logic [3:0] fa_d, ha_d, cb_d, fa_w, ha_w, cb_w;

    tree_mult4 #(.SCHED(SCHED_DADDA)) dut (
        .opa(a), .opb(b), .product(p_d),
        .fa_cells(fa_d), .ha_cells(ha_d), .cpa_bits(cb_d)
    );
    tree_mult4 #(.SCHED(SCHED_WALLACE)) dut_wal (
        .opa(a), .opb(b), .product(p_w),
        .fa_cells(fa_w), .ha_cells(ha_w), .cpa_bits(cb_w)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // {opa, opb, expected product}
    localparam logic [15:0] VEC [10] = '{
        {4'd0,  4'd0,  8'd0},   {4'd15, 4'd15, 8'd225},
        {4'd15, 4'd1,  8'd15},  {4'd1,  4'd15, 8'd15},
        {4'd8,  4'd8,  8'd64},  {4'd0,  4'd15, 8'd0},
        {4'd15, 4'd0,  8'd0},   {4'd12, 4'd11, 8'd132},
        {4'd9,  4'd14, 8'd126}, {4'd7,  4'd13, 8'd91}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] va, input logic [3:0] vb);
        @(negedge clk);
        a = va;
        b = vb;
        #2;
    endtask

    initial begin
        a = '0;
        b = '0;
        #2;
        // Idle state: zero operands (R7)
        chk("R7 idle", p_d, 8'd0);
        chk("R7 idle", p_w, 8'd0);

        // Corner table, both schedules (R1, R2)
        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][15:12], VEC[i][11:8]);
            chk("R1 table", p_d, VEC[i][7:0]);
            chk("R2 table", p_w, VEC[i][7:0]);
        end

        // Exhaustive sweep (R1, R2, R8)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                apply(4'(i), 4'(j));
                chk("R1 sweep", p_d, 8'(i * j));
                chk("R2 sweep", p_w, 8'(i * j));
                chk("R8 bound", 8'(p_d > 8'd225), 8'd0);
                chk("R9 lsb", 8'(p_w[0]), 8'(i & j & 1));
            end
        end

        // Zero on either side (R7)
        for (int i = 1; i < 16; i++) begin
            apply(4'(i), 4'd0);
            chk("R7 opb zero", p_d, 8'd0);
            apply(4'd0, 4'(i));
            chk("R7 opa zero", p_w, 8'd0);
        end

        // Top bit around the 128 threshold (R3)
        apply(4'd8, 4'd15);   // 120
        chk("R3 below", 8'(p_d[7]), 8'd0);
        chk("R3 below", 8'(p_w[7]), 8'd0);
        apply(4'd8, 4'd16 - 4'd0); // wraps to 0 operand guard not used
        apply(4'd11, 4'd12);  // 132
        chk("R3 above", 8'(p_d[7]), 8'd1);
        chk("R3 above", 8'(p_w[7]), 8'd1);
        apply(4'd15, 4'd15);  // 225
        chk("R3 max", 8'(p_d[7]), 8'd1);

        // LSB bypass (R9)
        apply(4'd1, 4'd1);
        chk("R9 lsb set", 8'(p_d[0]), 8'd1);
        apply(4'd3, 4'd2);
        chk("R9 lsb clear", 8'(p_d[0]), 8'd0);

        // Cell budgets and final adder widths (R4, R5, R6)
        chk("R4 dadda FA", 8'(fa_d), 8'd4);
        chk("R4 dadda HA", 8'(ha_d), 8'd2);
        chk("R5 wallace FA", 8'(fa_w), 8'd5);
        chk("R5 wallace HA", 8'(ha_w), 8'd3);
        chk("R6 dadda CPA", 8'(cb_d), 8'd6);
        chk("R6 wallace CPA", 8'(cb_w), 8'd4);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule